// File: doc/BRIEF.md
# Min-Sum Check-Node Unit with Selectable Correction

This block performs the check-node half of a min-sum LDPC decoder for a single parity row with up to eight connected edges. Each cycle it may take one row of signed fixed-point variable-to-check LLRs and, one clock later, it returns a check-to-variable message for every edge. Each output magnitude comes from the smallest magnitude among the other active edges of the row, so no tanh-style arithmetic is needed. Each output sign is the parity of the other edges' signs.

Plain min-sum overestimates reliabilities. For that reason every outgoing magnitude passes through a correction step before it leaves the block. The correction is either a shift-add scale factor below one or a subtracted offset. A mode input picks the kind of correction. A 3-bit correction code picks the strength, and it is taken either from a fixed entry or from a small per-iteration table indexed by the decoder's iteration counter. The table is loaded through a simple write port. Results are clamped symmetrically to the message width.

A row-degree input lets rows with fewer than eight edges share the same hardware. Unused edge lanes take no part in the computation and return zero.

Top module: `minsum_check_unit`

## Requirements
- R1: `outValid` is `inValid` delayed by exactly one clock. After reset, `outValid` is 0 and every lane of `outMsg` is 0.
- R2: Before correction, the output magnitude of the active edge holding the smallest input magnitude is the second-smallest active magnitude. Every other active edge gets the smallest. When magnitudes tie, the lowest edge index counts as the smallest. If only one edge is active, its pre-correction magnitude is 31 (the largest code).
- R3: An output's sign is the XOR of the sign bits of all active inputs, XORed again with that edge's own sign bit. A zero input counts as positive.
- R4: With `corrMode`=0 (scale), codes 0,1,2,3 scale the magnitude by 4/8, 5/8, 6/8, 7/8, and codes 4 to 7 scale it by 8/8. The product is truncated toward zero before the sign is applied.
- R5: With `corrMode`=1 (offset), the code value (0 to 7) is subtracted from the magnitude. The result is floored at zero.
- R6: With `adaptEn`=1, the code is taken from table entry `iterIdx`, and iterations of 7 or more use entry 7. With `adaptEn`=0, entry 0 is used for every iteration.
- R7: A table write (`tblWrEn`, `tblWrAddr`, `tblWrData`) takes effect at the clock edge. A row presented in the same cycle as the write still sees the old entry. Reset loads code 2 into every entry.
- R8: Edge i is active when i < `rowDegree`, and a degree above 8 counts as 8. Inactive lanes output 0 and do not affect any other lane's magnitude or sign.
- R9: Every output lies within -31..+31, so code -32 (6'b100000) is never produced. An input of -32 is taken as magnitude 31 with a negative sign.
- R10: `outMsg` holds its value in any cycle that follows a clock edge at which `inValid` was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | A row is presented this cycle |
| inLlr | input | MAX_DEG*MSG_W (48) | Edge LLRs in two's complement, edge i in bits [i*MSG_W +: MSG_W] |
| rowDegree | input | DEG_W (4) | Number of active edges |
| iterIdx | input | ITER_W (5) | Current decoder iteration |
| corrMode | input | 1 | 0 = scale, 1 = offset |
| adaptEn | input | 1 | 1 = per-iteration table lookup, 0 = fixed entry 0 |
| tblWrEn | input | 1 | Table write strobe |
| tblWrAddr | input | 3 | Table entry to write |
| tblWrData | input | 3 | Correction code to store |
| outValid | output | 1 | Output messages are valid |
| outMsg | output | MAX_DEG*MSG_W (48) | Check-to-variable messages, same lane layout as `inLlr` |

## Verification
On every cycle, the assertions check four things: the one-cycle valid delay, the absence of the most negative code in any lane, the zeroing of lanes beyond the row degree, and the holding of `outMsg` when no row is accepted. The arithmetic itself cannot be seen from a single cycle. That covers which edge receives the second minimum, tie resolution, sign parity with zero inputs, each scale and offset code, the iteration-to-entry mapping with its clamp, and the timing of a table write against a row in the same cycle. The bench's directed scenarios show these by comparing each lane with values worked out from the requirements.

// File: rtl/mscu_pkg.sv
package mscu_pkg;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_RESET = 3'd2;

  typedef struct packed {
    logic              load;
    logic              offsetMode;
    logic [CODE_W-1:0] code;
  } corrStrobe_t;
endpackage

// File: rtl/mscu_ctrl.sv
module mscu_ctrl
  import mscu_pkg::*;
#(
  parameter int ITER_W    = 5,
  parameter int TBL_DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         inValid,
  input  logic [ITER_W-1:0]            iterIdx,
  input  logic                         corrMode,
  input  logic                         adaptEn,
  input  logic                         tblWrEn,
  input  logic [$clog2(TBL_DEPTH)-1:0] tblWrAddr,
  input  logic [CODE_W-1:0]            tblWrData,
  output corrStrobe_t                  strobe,
  output logic                         outValid
);
  localparam int TBL_AW = $clog2(TBL_DEPTH);
  localparam int LAST   = TBL_DEPTH - 1;

  logic [CODE_W-1:0] codeTbl [TBL_DEPTH];
  logic [TBL_AW-1:0] entrySel;

  // Correction table: one code per iteration, last entry reused past the end.
  for (genvar e = 0; e < TBL_DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        codeTbl[e] <= CODE_RESET;
      end else if (tblWrEn && tblWrAddr == TBL_AW'(e)) begin
        codeTbl[e] <= tblWrData;
      end
    end
  end

  always_comb begin
    if (!adaptEn) begin
      entrySel = '0;
    end else if (32'(iterIdx) >= LAST) begin
      entrySel = TBL_AW'(LAST);
    end else begin
      entrySel = TBL_AW'(iterIdx);
    end
  end

  always_comb begin
    strobe.load       = inValid;
    strobe.offsetMode = corrMode;
    strobe.code       = codeTbl[entrySel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
    end
  end
endmodule

// File: rtl/mscu_datapath.sv
module mscu_datapath
  import mscu_pkg::*;
#(
  parameter int MSG_W   = 6,
  parameter int MAX_DEG = 8,
  parameter int DEG_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [MAX_DEG*MSG_W-1:0] inLlr,
  input  logic [DEG_W-1:0]         rowDegree,
  input  corrStrobe_t              strobe,
  output logic [MAX_DEG*MSG_W-1:0] outMsg
);
  localparam int MAG_W   = MSG_W - 1;
  localparam int MAX_MAG = (1 << MAG_W) - 1;
  localparam int IDX_W   = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1;
  localparam int ACC_W   = MAG_W + 3;

  logic [DEG_W-1:0]         degEff;
  logic [MAX_DEG-1:0]       edgeActive;
  logic [MAX_DEG-1:0]       edgeSign;
  logic [MAG_W-1:0]         edgeMag [MAX_DEG];
  logic [MAG_W-1:0]         min1, min2;
  logic [IDX_W-1:0]         min1Idx;
  logic                     parity;
  logic [MAX_DEG*MSG_W-1:0] rowNext;

  // Shift-add scale or floored offset, then clamp to the magnitude range.
  function automatic logic [MAG_W-1:0] correct(input logic [MAG_W-1:0] m,
                                                input logic off,
                                                input logic [CODE_W-1:0] c);
    logic [ACC_W-1:0] mw;
    logic [ACC_W-1:0] cw;
    logic [ACC_W-1:0] acc;
    mw = ACC_W'(m);
    cw = ACC_W'(c);
    if (off) begin
      acc = (mw > cw) ? (mw - cw) : '0;
    end else begin
      case (c)
        3'd0:    acc = (mw << 2) >> 3;
        3'd1:    acc = ((mw << 2) + mw) >> 3;
        3'd2:    acc = ((mw << 2) + (mw << 1)) >> 3;
        3'd3:    acc = ((mw << 3) - mw) >> 3;
        default: acc = mw;
      endcase
    end
    return (acc > ACC_W'(MAX_MAG)) ? MAG_W'(MAX_MAG) : acc[MAG_W-1:0];
  endfunction

  assign degEff = (32'(rowDegree) > MAX_DEG) ? DEG_W'(MAX_DEG) : rowDegree;

  for (genvar g = 0; g < MAX_DEG; g++) begin : g_edge
    logic [MSG_W-1:0] raw;
    logic [MSG_W-1:0] absVal;
    assign raw           = inLlr[g*MSG_W +: MSG_W];
    assign edgeActive[g] = (32'(g) < 32'(degEff));
    assign edgeSign[g]   = raw[MSG_W-1];
    assign absVal        = raw[MSG_W-1] ? (~raw + 1'b1) : raw;
    assign edgeMag[g]    = (32'(absVal) > MAX_MAG) ? MAG_W'(MAX_MAG) : absVal[MAG_W-1:0];
  end

  // Two-minimum search with strict comparison: ties keep the lower index.
  always_comb begin
    min1    = MAG_W'(MAX_MAG);
    min2    = MAG_W'(MAX_MAG);
    min1Idx = '0;
    parity  = 1'b0;
    for (int i = 0; i < MAX_DEG; i++) begin
      if (edgeActive[i]) begin
        parity = parity ^ edgeSign[i];
        if (edgeMag[i] < min1) begin
          min2    = min1;
          min1    = edgeMag[i];
          min1Idx = IDX_W'(i);
        end else if (edgeMag[i] < min2) begin
          min2 = edgeMag[i];
        end
      end
    end
  end

  for (genvar g = 0; g < MAX_DEG; g++) begin : g_lane
    logic [MAG_W-1:0] pick;
    logic [MAG_W-1:0] fixedMag;
    logic [MSG_W-1:0] posVal;
    assign pick     = (min1Idx == IDX_W'(g)) ? min2 : min1;
    assign fixedMag = correct(pick, strobe.offsetMode, strobe.code);
    assign posVal   = {1'b0, fixedMag};
    assign rowNext[g*MSG_W +: MSG_W] =
      !edgeActive[g]            ? '0 :
      (parity ^ edgeSign[g])    ? (~posVal + 1'b1) : posVal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outMsg <= '0;
    end else if (strobe.load) begin
      outMsg <= rowNext;
    end
  end
endmodule

// File: rtl/minsum_check_unit.sv
module minsum_check_unit
  import mscu_pkg::*;
#(
  parameter int MSG_W     = 6,
  parameter int MAX_DEG   = 8,
  parameter int ITER_W    = 5,
  parameter int TBL_DEPTH = 8,
  localparam int DEG_W    = $clog2(MAX_DEG + 1),
  localparam int TBL_AW   = $clog2(TBL_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inValid,
  input  logic [MAX_DEG*MSG_W-1:0] inLlr,
  input  logic [DEG_W-1:0]         rowDegree,
  input  logic [ITER_W-1:0]        iterIdx,
  input  logic                     corrMode,
  input  logic                     adaptEn,
  input  logic                     tblWrEn,
  input  logic [TBL_AW-1:0]        tblWrAddr,
  input  logic [CODE_W-1:0]        tblWrData,
  output logic                     outValid,
  output logic [MAX_DEG*MSG_W-1:0] outMsg
);
  corrStrobe_t strobe;

  mscu_ctrl #(.ITER_W(ITER_W), .TBL_DEPTH(TBL_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .iterIdx(iterIdx),
    .corrMode(corrMode), .adaptEn(adaptEn), .tblWrEn(tblWrEn),
    .tblWrAddr(tblWrAddr), .tblWrData(tblWrData),
    .strobe(strobe), .outValid(outValid)
  );

  mscu_datapath #(.MSG_W(MSG_W), .MAX_DEG(MAX_DEG), .DEG_W(DEG_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .inLlr(inLlr), .rowDegree(rowDegree),
    .strobe(strobe), .outMsg(outMsg)
  );
endmodule

// File: rtl/mscu_checker.sv
module mscu_checker #(
  parameter int MSG_W   = 6,
  parameter int MAX_DEG = 8,
  parameter int DEG_W   = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     inValid,
  input logic [DEG_W-1:0]         rowDegree,
  input logic                     outValid,
  input logic [MAX_DEG*MSG_W-1:0] outMsg
);
  localparam logic [MSG_W-1:0] MOST_NEG = {1'b1, {(MSG_W-1){1'b0}}};

  function automatic logic hasMostNeg(input logic [MAX_DEG*MSG_W-1:0] v);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < MAX_DEG; i++) begin
      if (v[i*MSG_W +: MSG_W] == MOST_NEG) hit = 1'b1;
    end
    return hit;
  endfunction

  function automatic logic unusedZero(input logic [MAX_DEG*MSG_W-1:0] v,
                                      input logic [DEG_W-1:0] d);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < MAX_DEG; i++) begin
      if (32'(i) >= 32'(d) && v[i*MSG_W +: MSG_W] != '0) ok = 1'b0;
    end
    return ok;
  endfunction

  // R1: output valid follows input valid by one cycle
  p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  // R9: the most negative code never appears on any lane
  p_no_most_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hasMostNeg(outMsg));

  // R8: lanes at or beyond the row degree come out zero
  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> unusedZero(outMsg, $past(rowDegree)));

  // R10: output held when no row was accepted
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(outMsg));
endmodule

bind minsum_check_unit mscu_checker #(
  .MSG_W(MSG_W), .MAX_DEG(MAX_DEG), .DEG_W(DEG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .rowDegree(rowDegree),
  .outValid(outValid), .outMsg(outMsg)
);

// File: tb/minsum_check_unit_tb.sv
module minsum_check_unit_tb;
  localparam int W = 6;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic [D*W-1:0] inLlr = '0;
  logic [3:0]   rowDegree = 4'd8;
  logic [4:0]   iterIdx = '0;
  logic         corrMode = 1'b0;
  logic         adaptEn = 1'b0;
  logic         tblWrEn = 1'b0;
  logic [2:0]   tblWrAddr = '0;
  logic [2:0]   tblWrData = '0;
  logic         outValid;
  logic [D*W-1:0] outMsg;

  int nChecks = 0;
  int nFails  = 0;
  int shadow [8];
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  minsum_check_unit u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inLlr(inLlr),
    .rowDegree(rowDegree), .iterIdx(iterIdx), .corrMode(corrMode),
    .adaptEn(adaptEn), .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr),
    .tblWrData(tblWrData), .outValid(outValid), .outMsg(outMsg)
  );

  function automatic logic [D*W-1:0] pack8(input int v0, v1, v2, v3, v4, v5, v6, v7);
    int vals [8];
    logic [D*W-1:0] r;
    vals = '{v0, v1, v2, v3, v4, v5, v6, v7};
    for (int i = 0; i < 8; i++) r[i*W +: W] = W'(vals[i]);
    return r;
  endfunction

  // Reference row built from the requirements with integer arithmetic.
  function automatic logic [D*W-1:0] model(input logic [D*W-1:0] llr, input int deg,
                                            input bit off, input int code);
    int mag [8];
    int neg [8];
    int n, m1, m1i, m2, par, base, res;
    logic [D*W-1:0] r;
    n = (deg > 8) ? 8 : deg;
    r = '0;
    par = 0;
    m1 = 31; m1i = -1;
    for (int i = 0; i < n; i++) begin
      int s;
      s = $signed(llr[i*W +: W]);
      neg[i] = (s < 0);
      mag[i] = (s < 0) ? -s : s;
      if (mag[i] > 31) mag[i] = 31;
      par ^= neg[i];
    end
    for (int i = 0; i < n; i++) if (m1i < 0 || mag[i] < m1) begin m1 = mag[i]; m1i = i; end
    m2 = 31;
    for (int i = 0; i < n; i++) if (i != m1i && mag[i] < m2) m2 = mag[i];
    for (int i = 0; i < n; i++) begin
      base = (i == m1i) ? m2 : m1;
      if (off) res = (base > code) ? base - code : 0;
      else     res = (base * ((code >= 4) ? 8 : 4 + code)) / 8;
      if (res > 31) res = 31;
      r[i*W +: W] = W'((par ^ neg[i]) ? -res : res);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [D*W-1:0] act,
                       input logic [D*W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeEntry(input int a, input int c);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrAddr = 3'(a); tblWrData = 3'(c);
    @(negedge clk);
    tblWrEn = 1'b0;
    shadow[a] = c;
  endtask

  // Present one row, then compare outMsg one cycle later.
  task automatic runRow(input string tag, input logic [D*W-1:0] llr, input int deg,
                        input int iter, input bit off, input bit adapt);
    int idx, code;
    logic [D*W-1:0] exp;
    idx  = adapt ? ((iter > 7) ? 7 : iter) : 0;
    code = shadow[idx];
    exp  = model(llr, deg, off, code);
    @(negedge clk);
    inValid = 1'b1; inLlr = llr; rowDegree = 4'(deg); iterIdx = 5'(iter);
    corrMode = off; adaptEn = adapt;
    @(negedge clk);
    inValid = 1'b0;
    check(outMsg == exp, tag, outMsg, exp);
    check(outValid == 1'b1, {tag, " R1 valid"}, D*W'(outValid), D*W'(1));
  endtask

  task automatic t_reset();
    check(outValid == 1'b0 && outMsg == '0, "R1 reset state", outMsg, '0);
    for (int i = 0; i < 8; i++) shadow[i] = 2;
  endtask

  task automatic t_basic();  // R2 R4 with reset code 2 (0.75)
    runRow("R2 basic", pack8(3, -5, 7, 10, -2, 6, 9, 12), 8, 0, 0, 0);
    @(negedge clk);
    check(outValid == 1'b0, "R1 valid drop", D*W'(outValid), '0);
  endtask

  task automatic t_tie();    // R2 tie goes to lowest index
    runRow("R2 tie", pack8(9, 4, 12, 4, 20, 15, 4, 30), 8, 0, 0, 0);
    runRow("R2 all equal", pack8(8, 8, 8, 8, 8, 8, 8, 8), 8, 0, 0, 0);
  endtask

  task automatic t_sign();   // R3 parity, zero counts positive
    runRow("R3 zero inputs", pack8(0, -7, 11, -9, 0, 14, -20, 25), 8, 0, 0, 0);
    runRow("R3 odd negatives", pack8(-6, 10, -12, -14, 18, 9, 22, 27), 8, 0, 0, 0);
  endtask

  task automatic t_scale();  // R4 every code via entry 0; R7 writes
    for (int c = 0; c < 8; c++) begin
      writeEntry(0, c);
      runRow($sformatf("R4 scale code %0d", c), pack8(13, -17, 21, 25, -29, 19, 23, 31), 8, 0, 0, 0);
    end
  endtask

  task automatic t_offset(); // R5 subtract with floor at zero
    for (int c = 0; c < 8; c++) begin
      writeEntry(0, c);
      runRow($sformatf("R5 offset code %0d", c), pack8(3, -5, 9, 14, -2, 30, 6, 11), 8, 0, 1, 0);
    end
  endtask

  task automatic t_iter();   // R6 table lookup by iteration with clamp
    for (int e = 0; e < 8; e++) writeEntry(e, (e * 3 + 1) % 8);
    for (int it = 0; it < 12; it++)
      runRow($sformatf("R6 iter %0d", it), pack8(20, -24, 28, 22, -26, 30, 21, 27), 8, it, 1, 1);
    runRow("R6 fixed entry at iter 5", pack8(20, -24, 28, 22, -26, 30, 21, 27), 8, 5, 1, 0);
  endtask

  task automatic t_wrTiming(); // R7 same-cycle write sees old entry
    logic [D*W-1:0] llr, expOld, expNew;
    llr = pack8(18, -22, 26, 20, -24, 28, 19, 25);
    writeEntry(0, 0);
    expOld = model(llr, 8, 1, 0);
    expNew = model(llr, 8, 1, 6);
    @(negedge clk);
    inValid = 1'b1; inLlr = llr; rowDegree = 4'd8; corrMode = 1'b1; adaptEn = 1'b0;
    tblWrEn = 1'b1; tblWrAddr = 3'd0; tblWrData = 3'd6;
    @(negedge clk);
    tblWrEn = 1'b0;
    check(outMsg == expOld, "R7 write same cycle uses old", outMsg, expOld);
    @(negedge clk);
    inValid = 1'b0;
    check(outMsg == expNew, "R7 write visible next cycle", outMsg, expNew);
    shadow[0] = 6;
  endtask

  task automatic t_degree(); // R8 masking, degree 1, 0 and above 8
    writeEntry(0, 4);
    runRow("R8 degree 3", pack8(9, -4, 12, -1, 2, -3, 5, 0), 3, 0, 0, 0);
    runRow("R8 degree 1", pack8(-7, 1, 1, 1, 1, 1, 1, 1), 1, 0, 0, 0);
    runRow("R8 degree 0", pack8(5, 6, 7, 8, 9, 10, 11, 12), 0, 0, 0, 0);
    runRow("R8 degree 12", pack8(5, -6, 7, 8, 9, 10, 11, 12), 12, 0, 0, 0);
  endtask

  task automatic t_sat();    // R9 most negative input and full-scale output
    runRow("R9 saturate", pack8(-32, -32, -32, 31, 31, 31, 31, 31), 8, 0, 0, 0);
    check(outMsg[W-1:0] != 6'b100000, "R9 no most-negative", outMsg, '0);
  endtask

  task automatic t_hold();   // R10 output holds without valid
    logic [D*W-1:0] prev;
    runRow("R10 setup", pack8(4, -8, 12, 16, -20, 24, 28, 30), 8, 0, 0, 0);
    prev = outMsg;
    @(negedge clk);
    inLlr = pack8(1, 1, 1, 1, 1, 1, 1, 1); corrMode = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(outMsg == prev && outValid == 1'b0, "R10 hold", outMsg, prev);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_tie();
    t_sign();
    t_scale();
    t_offset();
    t_iter();
    t_wrTiming();
    t_degree();
    t_sat();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule